// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block connects a synchronous host request port to an external asynchronous static RAM of 512K words by 16 bits. The host presents a word address, write data, a write flag and two active-high byte-lane enables with a single-cycle request. The controller then steps the memory pins through fixed, parameterised phases. A write has address setup, a write strobe, a hold cycle and completion. A read has bus turnaround, an output-enable access window and completion. Every access ends with a one-cycle done pulse.

The memory counts as selected only when its active-low first chip enable is low and its active-high second chip enable is high. The controller deselects the memory whenever no access is in progress, which lets the memory fall into standby. The controller drives the shared data bus only while the write strobe is low. In every other cycle the bus floats, so the two sides never drive it together.

A request with both lane enables clear does no memory cycle. It still completes with a done pulse. Requests that arrive while an access is in progress are ignored.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is held and after it, the pins are as follows. First chip enable is high, second chip enable is low, write and output enables are high, both lane pins are high, the data bus floats, and done and busy are low.
- R2: Outside an access, and in the done cycle, the memory is deselected, with write and output enables high and the data bus released. It is selected, with first enable low and second enable high, only in the setup, strobe, hold, turnaround and access cycles.
- R3: A write first spends SETUP_CYC cycles selected, with address and lane pins stable, write enable high and the bus floating.
- R4: Write enable then stays low for PULSE_CYC cycles. The write data appears on the bus in exactly those cycles.
- R5: After write enable rises there is one hold cycle. In it the memory stays selected with the same address and lane pins, and the bus is released.
- R6: During an access, lane pin bit 0 is low exactly when host enable bit 0 was set. That lane covers data bits 7:0. Lane pin bit 1 and data bits 15:8 follow host enable bit 1 in the same way.
- R7: A read spends one turnaround cycle selected, with output enable high and the bus released. Output enable then stays low for ACCESS_CYC cycles. Write enable stays high throughout, and the two enables are never low together.
- R8: The read result is taken from the bus in the last access cycle and presented with done in the next cycle. Bits of lanes that were not enabled read as zero.
- R9: Each accepted request produces exactly one done cycle, followed by an idle cycle in which busy is low.
- R10: A request with both enables clear asserts no strobe and leaves the memory deselected. Done appears in the cycle after acceptance.
- R11: A request seen while busy, including in the done cycle, is ignored. A request held high is taken again only after an idle, deselected cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Request, taken when not busy |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Word address |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Lane enables, bit 0 = bits 7:0 |
| host_busy | output | 1 | Access in progress |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read result, valid with done |
| mem_ce1_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Lane enables, active low, bit 0 = low byte |
| mem_addr | output | 19 | Memory word address |
| mem_dq | inout | 16 | Bidirectional data bus |

## Verification
The memory pins are decoded straight from the phase state. A wrong state or an off-by-one phase counter therefore shows at the pins in the very next cycle: a strobe edge arrives early or late, the chip is selected in an idle cycle, or a lane pin is wrong. When the controller drives the bus out of turn, the probe value the bench places on a floating bus is corrupted in that same cycle. A wrong lane mask or a wrong capture cycle shows as a bad read result in the done cycle, one cycle after the last access cycle.

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl #(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 16,
  parameter int SETUP_CYC  = 2,
  parameter int PULSE_CYC  = 3,
  parameter int ACCESS_CYC = 3
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_req,
  input  logic                  host_we,
  input  logic [ADDR_W-1:0]     host_addr,
  input  logic [DATA_W-1:0]     host_wdata,
  input  logic [DATA_W/8-1:0]   host_be,
  output logic                  host_busy,
  output logic                  host_done,
  output logic [DATA_W-1:0]     host_rdata,
  output logic                  mem_ce1_n,
  output logic                  mem_ce2,
  output logic                  mem_we_n,
  output logic                  mem_oe_n,
  output logic [DATA_W/8-1:0]   mem_be_n,
  output logic [ADDR_W-1:0]     mem_addr,
  inout  wire  [DATA_W-1:0]     mem_dq
);
  localparam int LANES = DATA_W / 8;
  localparam int MAX_A = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAXC  = (MAX_A > ACCESS_CYC) ? MAX_A : ACCESS_CYC;
  localparam int CW    = $clog2(MAXC + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WSET, S_WPUL, S_WHLD, S_RTRN, S_RACC, S_DONE
  } phase_t;

  phase_t            state;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] a_q;
  logic [DATA_W-1:0] d_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] lane_mask;
  logic              sel, dq_en;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_mask[8*i +: 8] = {8{be_q[i]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      a_q        <= '0;
      d_q        <= '0;
      be_q       <= '0;
      host_rdata <= '0;
    end else begin
      case (state)
        S_IDLE: if (host_req) begin
          a_q  <= host_addr;
          d_q  <= host_wdata;
          be_q <= host_be;
          if (host_be == '0) state <= S_DONE;
          else if (host_we) begin
            state <= S_WSET;
            cnt   <= CW'(SETUP_CYC - 1);
          end else state <= S_RTRN;
        end
        S_WSET: if (cnt == '0) begin
          state <= S_WPUL;
          cnt   <= CW'(PULSE_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_WPUL: if (cnt == '0) state <= S_WHLD;
                else cnt <= cnt - 1'b1;
        S_WHLD: state <= S_DONE;
        S_RTRN: begin
          state <= S_RACC;
          cnt   <= CW'(ACCESS_CYC - 1);
        end
        S_RACC: if (cnt == '0) begin
          host_rdata <= mem_dq & lane_mask;
          state      <= S_DONE;
        end else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign sel       = (state == S_WSET) || (state == S_WPUL) || (state == S_WHLD) ||
                     (state == S_RTRN) || (state == S_RACC);
  assign dq_en     = (state == S_WPUL);
  assign mem_ce1_n = !sel;
  assign mem_ce2   = sel;
  assign mem_we_n  = !dq_en;
  assign mem_oe_n  = (state != S_RACC);
  assign mem_be_n  = sel ? ~be_q : '1;
  assign mem_addr  = a_q;
  assign mem_dq    = dq_en ? d_q : 'z;
  assign host_done = (state == S_DONE);
  assign host_busy = (state != S_IDLE);

  p_desel_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !host_busy |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !dq_en));

  p_setup_before_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(!mem_ce1_n) && $stable(mem_addr) && $stable(mem_be_n)));

  p_hold_after_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce1_n && mem_ce2 && $stable(mem_addr) && $stable(mem_be_n) && !dq_en));

  p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> ($past(!mem_ce1_n) && $past(mem_oe_n) && $past(!dq_en)));

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> (!host_done && !host_busy));

  p_noop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_busy && host_req && host_be == '0) |=> (host_done && mem_ce1_n && mem_we_n && mem_oe_n));
endmodule

// File: tb/tb_sram_lane_ctrl.sv
`timescale 1ns/1ps
module tb_sram_lane_ctrl;
  localparam int SETUP_CYC = 2, PULSE_CYC = 3, ACCESS_CYC = 3;
  localparam logic [15:0] PROBE = 16'hC35A;

  logic clk = 0, rst_n = 0;
  logic host_req = 0, host_we = 0;
  logic [18:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [1:0]  host_be = '0;
  logic host_busy, host_done, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n;
  logic [15:0] host_rdata;
  logic [1:0]  mem_be_n;
  logic [18:0] mem_addr;
  wire  [15:0] mem_dq;

  always #10 clk = ~clk;

  sram_lane_ctrl dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
    .host_busy(host_busy), .host_done(host_done), .host_rdata(host_rdata),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq(mem_dq));

  // memory model plus a probe that fills any floating lane
  logic [15:0] sram [int];
  logic [15:0] rd_word;
  wire msel  = !mem_ce1_n && mem_ce2;
  wire rd_lo = msel && !mem_oe_n && mem_we_n && !mem_be_n[0];
  wire rd_hi = msel && !mem_oe_n && mem_we_n && !mem_be_n[1];
  always_comb rd_word = sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : 16'h0000;
  assign mem_dq[7:0]  = rd_lo ? rd_word[7:0]  : 8'hzz;
  assign mem_dq[15:8] = rd_hi ? rd_word[15:8] : 8'hzz;
  assign mem_dq[7:0]  = (mem_we_n && !rd_lo) ? PROBE[7:0]  : 8'hzz;
  assign mem_dq[15:8] = (mem_we_n && !rd_hi) ? PROBE[15:8] : 8'hzz;
  always @(posedge clk) if (msel && !mem_we_n) begin
    logic [15:0] w;
    w = sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : 16'h0000;
    if (!mem_be_n[0]) w[7:0]  = mem_dq[7:0];
    if (!mem_be_n[1]) w[15:8] = mem_dq[15:8];
    sram[int'(mem_addr)] = w;
  end

  typedef struct {
    logic sel; logic we_n; logic oe_n; logic [1:0] be_n; logic [18:0] addr;
    logic [15:0] dq; logic done; logic rchk; logic [15:0] rdata; string tag;
  } exp_t;

  exp_t exp_q[$];
  logic [15:0] ref_mem [int];
  int n_run = 0, n_fail = 0;
  logic cur_done = 0;

  task automatic chk(string r, logic [31:0] act, logic [31:0] expv, string what);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", r, what, act, expv, $time);
    end
  endtask

  function automatic exp_t mk(logic s, logic w, logic o, logic [1:0] b, logic [18:0] a,
                              logic [15:0] d, logic dn, string t);
    exp_t e;
    e.sel = s; e.we_n = w; e.oe_n = o; e.be_n = b; e.addr = a; e.dq = d;
    e.done = dn; e.rchk = 0; e.rdata = '0; e.tag = t;
    return e;
  endfunction

  task automatic push_seq(logic [18:0] a, logic [15:0] d, logic w, logic [1:0] be);
    exp_t e;
    logic [15:0] m, rv, bus;
    if (be == 2'b00) begin
      exp_q.push_back(mk(0, 1, 1, 2'b11, a, PROBE, 1, "R10"));
      return;
    end
    m = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
    if (w) begin
      for (int i = 0; i < SETUP_CYC; i++) exp_q.push_back(mk(1, 1, 1, ~be, a, PROBE, 0, "R3"));
      for (int i = 0; i < PULSE_CYC; i++) exp_q.push_back(mk(1, 0, 1, ~be, a, d, 0, "R4"));
      exp_q.push_back(mk(1, 1, 1, ~be, a, PROBE, 0, "R5"));
      exp_q.push_back(mk(0, 1, 1, 2'b11, a, PROBE, 1, "R9"));
      if (be[0]) m[7:0]  = d[7:0];
      if (be[1]) m[15:8] = d[15:8];
      ref_mem[int'(a)] = m;
    end else begin
      rv  = {be[1] ? m[15:8] : 8'h00, be[0] ? m[7:0] : 8'h00};
      bus = {be[1] ? m[15:8] : PROBE[15:8], be[0] ? m[7:0] : PROBE[7:0]};
      exp_q.push_back(mk(1, 1, 1, ~be, a, PROBE, 0, "R7"));
      for (int i = 0; i < ACCESS_CYC; i++) exp_q.push_back(mk(1, 1, 0, ~be, a, bus, 0, "R7"));
      e = mk(0, 1, 1, 2'b11, a, PROBE, 1, "R8");
      e.rchk = 1; e.rdata = rv;
      exp_q.push_back(e);
    end
  endtask

  task automatic step();
    exp_t e;
    logic busy_e;
    if (host_req && exp_q.size() == 0 && !cur_done) push_seq(host_addr, host_wdata, host_we, host_be);
    @(negedge clk);
    busy_e = (exp_q.size() != 0);
    if (busy_e) e = exp_q.pop_front();
    else e = mk(0, 1, 1, 2'b11, '0, PROBE, 0, "R2");
    chk(e.tag, 32'(mem_ce1_n), 32'(!e.sel), "ce1_n");
    chk(e.tag, 32'(mem_ce2), 32'(e.sel), "ce2");
    chk(e.tag, 32'(mem_we_n), 32'(e.we_n), "we_n");
    chk(e.tag, 32'(mem_oe_n), 32'(e.oe_n), "oe_n");
    chk(e.sel ? "R6" : e.tag, 32'(mem_be_n), 32'(e.be_n), "lane pins");
    chk(e.tag, 32'(mem_dq), 32'(e.dq), "data bus");
    chk(e.tag, 32'(host_done), 32'(e.done), "done");
    chk("R11", 32'(host_busy), 32'(busy_e), "busy");
    if (e.sel) chk(e.tag, 32'(mem_addr), 32'(e.addr), "address");
    if (e.rchk) chk("R8", 32'(host_rdata), 32'(e.rdata), "read data");
    cur_done = e.done;
  endtask

  task automatic access(logic w, logic [18:0] a, logic [15:0] d, logic [1:0] be);
    host_req = 1; host_we = w; host_addr = a; host_wdata = d; host_be = be;
    step();
    host_req = 0;
    while (exp_q.size() != 0) step();
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", 32'(mem_ce1_n), 32'd1, "ce1_n");
    chk("R1", 32'(mem_ce2), 32'd0, "ce2");
    chk("R1", 32'({mem_we_n, mem_oe_n}), 32'd3, "strobes");
    chk("R1", 32'(mem_be_n), 32'd3, "lanes");
    chk("R1", 32'(mem_dq), 32'(PROBE), "bus floats");
    chk("R1", 32'({host_done, host_busy}), 32'd0, "done/busy");
    rst_n = 1;
    step(); step();
    access(1, 19'h00000, 16'hBEEF, 2'b11);
    access(0, 19'h00000, 16'h0000, 2'b11);
    access(1, 19'h7FFFF, 16'h1234, 2'b11);
    access(1, 19'h7FFFF, 16'hAB56, 2'b01);   // R6 low lane only
    access(0, 19'h7FFFF, 16'h0000, 2'b11);
    access(1, 19'h7FFFF, 16'hCD00, 2'b10);   // R6 high lane only
    access(0, 19'h7FFFF, 16'h0000, 2'b01);   // R8 high lane zero
    access(0, 19'h7FFFF, 16'h0000, 2'b10);   // R8 low lane zero
    access(1, 19'h12345, 16'hFFFF, 2'b00);   // R10 no-op
    access(0, 19'h12345, 16'h0000, 2'b11);   // R10 nothing written
    // R11: request while busy is ignored
    host_req = 1; host_we = 1; host_addr = 19'h00042; host_wdata = 16'h5AA5; host_be = 2'b11;
    step();
    host_addr = 19'h00099; host_wdata = 16'h0F0F;
    step(); step();
    host_req = 0;
    while (exp_q.size() != 0) step();
    step();
    access(0, 19'h00099, 16'h0000, 2'b11);
    access(0, 19'h00042, 16'h0000, 2'b11);
    // R11: request held high across completion
    host_req = 1; host_we = 0; host_addr = 19'h00042; host_be = 2'b11;
    for (int i = 0; i < 20; i++) step();
    host_req = 0;
    while (exp_q.size() != 0) step();
    step(); step();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule